// File: doc/BRIEF.md
# Bit-Field Logic and Move Unit

This execution unit works on bit fields that can start at any bit of a 32-bit word. A field does not have to line up with a byte or word boundary. Each operation names a destination operand and a source operand. An operand is a register index plus a bit offset. One field width, from 1 to 32 bits, applies to both operands.

Logic operations read the destination field as their first input and write the result back into the same field. MOVE copies the source field into the destination field, and the two fields may sit at different offsets. In every case the result is merged into the destination word and every bit outside the field is kept. A source can also be an external input word, and a destination can also be an external output word that the unit holds. All arithmetic is fixed point.

A protocol-processing core issues one operation per cycle with a valid strobe. The merged word appears on a registered write-back bus one cycle after issue. It is committed to the register file, or to the output word, on the following edge. An operation issued in the next cycle that reads the pending word receives it by forwarding.

Top module: `bitfield_alu`

## Requirements
- R1: Opcode 0 (MOVE) writes bits [so+k] of the source into bits [do+k] of the destination, for k = 0 to W-1. The source is register `src_idx`, or `port_in` when `src_is_port` is 1.
- R2: Opcodes 1, 2 and 3 replace each destination field bit [do+k] with (dst[do+k] AND / OR / XOR src[so+k]).
- R3: Opcode 4 (NOT) replaces destination field bit [do+k] with the inverse of src[so+k].
- R4: Every destination bit outside [do, do+W-1] keeps its previous value in the written word.
- R5: Any offset from 0 to 31 and any width from 1 to 32 is legal. Width 1 and width 32 are included.
- R6: When do+W or so+W exceeds 32, the effective width is the smallest of W, 32-do and 32-so. The write still happens, and `wb_err` is 1 in the write-back cycle.
- R7: An operation with width 0 or opcode 5 to 7 writes nothing. It gives `wb_valid`=0 and `wb_err`=1 in the cycle after issue.
- R8: An operation issued in cycle t shows its merged word on `wb_data`, with `wb_valid`=1, in cycle t+1. `rd_data` for that register returns the word from cycle t+2. A cycle with no issue gives `wb_valid`=0 and `wb_err`=0 in the next cycle.
- R9: An operation issued in the cycle right after another one that writes the same register, or the output word, uses the pending result as its operand.
- R10: With `dst_is_port`=1, the field is merged into `port_out` one cycle after `wb_valid` and `wb_to_port` are high. At all other times `port_out` holds its value.
- R11: After reset, `wb_valid`=0, `wb_err`=0 and `port_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe |
| op_code | input | 3 | 0 MOVE, 1 AND, 2 OR, 3 XOR, 4 NOT, 5 to 7 illegal |
| dst_is_port | input | 1 | Destination is the output word |
| dst_idx | input | IDX_W | Destination register index |
| dst_off | input | OFF_W | Destination bit offset |
| src_is_port | input | 1 | Source is `port_in` |
| src_idx | input | IDX_W | Source register index |
| src_off | input | OFF_W | Source bit offset |
| fld_width | input | WID_W | Field width, 1 to 32 |
| port_in | input | DATA_W | External source word |
| rd_idx | input | IDX_W | Register read-back index |
| rd_data | output | DATA_W | Committed contents of register `rd_idx` |
| wb_valid | output | 1 | Write-back strobe |
| wb_to_port | output | 1 | Write-back targets the output word |
| wb_idx | output | IDX_W | Write-back register index |
| wb_data | output | DATA_W | Merged destination word |
| wb_err | output | 1 | Clipped width, zero width or illegal opcode |
| port_out | output | DATA_W | External destination word |

## Verification
Full-width moves from `port_in` set every register to a distinct value. Narrow, unaligned fields with different source and destination offsets then show whether the shift direction and the merge mask are right. Width 1 and width 32 probe the ends of the mask. Offsets near bit 31 separate clipping on the destination side from clipping on the source side.

Chains of operations on one register, or on the output word, tell forwarding apart from stale register reads. A read-back placed between the write-back cycle and the commit cycle pins the commit timing. A long random stream of opcodes, offsets and widths is compared word for word against a bit-by-bit reference model, so any bit disturbed outside the field is caught.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  typedef enum logic [2:0] {
    BF_MOVE = 3'd0,
    BF_AND  = 3'd1,
    BF_OR   = 3'd2,
    BF_XOR  = 3'd3,
    BF_NOT  = 3'd4
  } bf_op_e;

  function automatic logic bf_op_legal(input logic [2:0] code);
    return code <= 3'(BF_NOT);
  endfunction
endpackage

// File: rtl/bf_regfile.sv
module bf_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  parameter int IDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic [IDX_W-1:0]  rc_addr,
  output logic [DATA_W-1:0] rc_data
);
  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];
endmodule

// File: rtl/bf_operand_sel.sv
module bf_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [DATA_W-1:0] reg_dst,
  input  logic [DATA_W-1:0] reg_src,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic              dst_is_port,
  input  logic              src_is_port,
  input  logic [DATA_W-1:0] port_in,
  input  logic [DATA_W-1:0] port_out,
  input  logic              pend_valid,
  input  logic              pend_port,
  input  logic [IDX_W-1:0]  pend_idx,
  input  logic [DATA_W-1:0] pend_data,
  output logic [DATA_W-1:0] dst_word,
  output logic [DATA_W-1:0] src_word
);
  logic hit_dst_reg, hit_src_reg, hit_port;

  assign hit_dst_reg = pend_valid && !pend_port && (pend_idx == dst_idx);
  assign hit_src_reg = pend_valid && !pend_port && (pend_idx == src_idx);
  assign hit_port    = pend_valid && pend_port;

  always_comb begin
    if (dst_is_port) dst_word = hit_port ? pend_data : port_out;
    else             dst_word = hit_dst_reg ? pend_data : reg_dst;
    if (src_is_port) src_word = port_in;
    else             src_word = hit_src_reg ? pend_data : reg_src;
  end
endmodule

// File: rtl/bf_field_unit.sv
module bf_field_unit
  import bitfield_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = $clog2(DATA_W),
  parameter int WID_W  = OFF_W + 1
) (
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] dst_word,
  input  logic [DATA_W-1:0] src_word,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [WID_W-1:0]  fld_width,
  output logic [DATA_W-1:0] merged,
  output logic              do_write,
  output logic              flag_err
);
  localparam logic [WID_W-1:0] FULL = WID_W'(DATA_W);

  logic [WID_W-1:0]  dst_room, src_room, w_eff, lane_end;
  logic [DATA_W-1:0] src_aligned, op_word, fmask;
  logic              legal;

  assign dst_room = FULL - {1'b0, dst_off};
  assign src_room = FULL - {1'b0, src_off};

  always_comb begin
    w_eff = fld_width;
    if (dst_room < w_eff) w_eff = dst_room;
    if (src_room < w_eff) w_eff = src_room;
  end

  assign lane_end    = {1'b0, dst_off} + w_eff;
  assign src_aligned = (src_word >> src_off) << dst_off;

  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_lane
      assign fmask[i] = (WID_W'(i) >= {1'b0, dst_off}) && (WID_W'(i) < lane_end);
    end
  endgenerate

  always_comb begin
    case (op_code)
      3'(BF_MOVE): op_word = src_aligned;
      3'(BF_AND):  op_word = dst_word & src_aligned;
      3'(BF_OR):   op_word = dst_word | src_aligned;
      3'(BF_XOR):  op_word = dst_word ^ src_aligned;
      3'(BF_NOT):  op_word = ~src_aligned;
      default:     op_word = dst_word;
    endcase
  end

  assign merged   = (dst_word & ~fmask) | (op_word & fmask);
  assign legal    = bf_op_legal(op_code);
  assign do_write = legal && (fld_width != '0);
  assign flag_err = !legal || (fld_width == '0) || (w_eff != fld_width);
endmodule

// File: rtl/bitfield_alu.sv
module bitfield_alu #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  parameter int OFF_W  = $clog2(DATA_W),
  parameter int WID_W  = OFF_W + 1,
  parameter int IDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              dst_is_port,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic              src_is_port,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [WID_W-1:0]  fld_width,
  input  logic [DATA_W-1:0] port_in,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              wb_valid,
  output logic              wb_to_port,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_err,
  output logic [DATA_W-1:0] port_out
);
  logic [DATA_W-1:0] reg_dst, reg_src, dst_word, src_word, merged;
  logic              do_write, flag_err;

  bf_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .IDX_W(IDX_W)) u_rf (
    .clk     (clk),
    .we      (wb_valid && !wb_to_port),
    .waddr   (wb_idx),
    .wdata   (wb_data),
    .ra_addr (dst_idx),
    .ra_data (reg_dst),
    .rb_addr (src_idx),
    .rb_data (reg_src),
    .rc_addr (rd_idx),
    .rc_data (rd_data)
  );

  bf_operand_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
    .reg_dst     (reg_dst),
    .reg_src     (reg_src),
    .dst_idx     (dst_idx),
    .src_idx     (src_idx),
    .dst_is_port (dst_is_port),
    .src_is_port (src_is_port),
    .port_in     (port_in),
    .port_out    (port_out),
    .pend_valid  (wb_valid),
    .pend_port   (wb_to_port),
    .pend_idx    (wb_idx),
    .pend_data   (wb_data),
    .dst_word    (dst_word),
    .src_word    (src_word)
  );

  bf_field_unit #(.DATA_W(DATA_W), .OFF_W(OFF_W), .WID_W(WID_W)) u_fu (
    .op_code   (op_code),
    .dst_word  (dst_word),
    .src_word  (src_word),
    .dst_off   (dst_off),
    .src_off   (src_off),
    .fld_width (fld_width),
    .merged    (merged),
    .do_write  (do_write),
    .flag_err  (flag_err)
  );

  // write-back stage
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_err   <= 1'b0;
    end else begin
      wb_valid <= op_valid && do_write;
      wb_err   <= op_valid && flag_err;
    end
    wb_to_port <= dst_is_port;
    wb_idx     <= dst_idx;
    wb_data    <= merged;
  end

  // commit of the external output word
  always_ff @(posedge clk) begin
    if (rst)                          port_out <= '0;
    else if (wb_valid && wb_to_port)  port_out <= wb_data;
  end
endmodule

// File: rtl/bitfield_alu_chk.sv
module bitfield_alu_chk #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  parameter int OFF_W  = $clog2(DATA_W),
  parameter int WID_W  = OFF_W + 1,
  parameter int IDX_W  = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              src_is_port,
  input logic [OFF_W-1:0]  dst_off,
  input logic [OFF_W-1:0]  src_off,
  input logic [WID_W-1:0]  fld_width,
  input logic [DATA_W-1:0] port_in,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              wb_valid,
  input logic              wb_to_port,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [DATA_W-1:0] wb_data,
  input logic              wb_err,
  input logic [DATA_W-1:0] port_out
);
  // R7
  illegal_op_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > 3'd4) |=> (!wb_valid && wb_err));

  // R7
  zero_width_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && fld_width == '0) |=> (!wb_valid && wb_err));

  // R6
  over_width_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= 3'd4 && fld_width > WID_W'(DATA_W)) |=> (wb_valid && wb_err));

  // R1
  full_move_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd0 && src_is_port && fld_width == WID_W'(DATA_W)
     && dst_off == '0 && src_off == '0)
    |=> (wb_valid && !wb_err && wb_data == $past(port_in)));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!wb_valid && !wb_err));

  // R8
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_to_port) |=> (rd_idx != $past(wb_idx) || rd_data == $past(wb_data)));

  // R10
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && wb_to_port) |=> $stable(port_out));

  // R10
  port_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_to_port) |=> (port_out == $past(wb_data)));
endmodule

bind bitfield_alu bitfield_alu_chk #(.DATA_W(DATA_W), .NREGS(NREGS)) u_chk (.*);

// File: tb/test_bitfield_alu.sv
module test_bitfield_alu;
  localparam int DATA_W = 32;
  localparam int NREGS  = 8;
  localparam int OFF_W  = 5;
  localparam int WID_W  = 6;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              op_valid = 1'b0;
  logic [2:0]        op_code = '0;
  logic              dst_is_port = 1'b0;
  logic [IDX_W-1:0]  dst_idx = '0;
  logic [OFF_W-1:0]  dst_off = '0;
  logic              src_is_port = 1'b0;
  logic [IDX_W-1:0]  src_idx = '0;
  logic [OFF_W-1:0]  src_off = '0;
  logic [WID_W-1:0]  fld_width = '0;
  logic [DATA_W-1:0] port_in = '0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [DATA_W-1:0] rd_data;
  logic              wb_valid, wb_to_port, wb_err;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data, port_out;

  always #2.5 clk = ~clk;

  bitfield_alu #(.DATA_W(DATA_W), .NREGS(NREGS)) i_bitfield_alu (.*);

  typedef struct {
    logic              wr;
    logic              to_port;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
    logic              err;
    string             tag;
  } exp_t;

  exp_t              sbq[$];
  logic [DATA_W-1:0] mdl [NREGS];
  logic [DATA_W-1:0] mdl_port = '0;
  logic [DATA_W-1:0] mon_port = '0;
  logic              issued_q = 1'b0;
  int                n_chk = 0;
  int                n_fail = 0;
  bit                done = 0;

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bit-by-bit reference of one operation
  task automatic ref_op(input int op, input logic [DATA_W-1:0] dold, input logic [DATA_W-1:0] sw,
                        input int doff, input int soff, input int w,
                        output logic [DATA_W-1:0] res, output logic err, output logic wr);
    int weff;
    weff = w;
    if (doff + weff > DATA_W) weff = DATA_W - doff;
    if (soff + weff > DATA_W) weff = DATA_W - soff;
    wr  = (w != 0) && (op <= 4);
    err = (w == 0) || (op > 4) || (weff != w);
    res = dold;
    for (int k = 0; k < weff; k++) begin
      logic s, d;
      s = sw[soff + k];
      d = dold[doff + k];
      case (op)
        0: res[doff + k] = s;
        1: res[doff + k] = d & s;
        2: res[doff + k] = d | s;
        3: res[doff + k] = d ^ s;
        4: res[doff + k] = ~s;
        default: res[doff + k] = d;
      endcase
    end
  endtask

  // driver: one operation issued in the next cycle, expectation pushed
  task automatic issue(input int op, input logic dport, input int didx, input int doff,
                       input logic sport, input int sidx, input int soff, input int w,
                       input logic [DATA_W-1:0] pin, input string tag);
    logic [DATA_W-1:0] dold, sw, res;
    logic err, wr;
    exp_t it;
    dold = dport ? mdl_port : mdl[didx];
    sw   = sport ? pin : mdl[sidx];
    ref_op(op, dold, sw, doff, soff, w, res, err, wr);
    if (wr) begin
      if (dport) mdl_port = res;
      else       mdl[didx] = res;
    end
    it.wr = wr; it.to_port = dport; it.idx = IDX_W'(didx);
    it.data = res; it.err = err; it.tag = tag;
    @(negedge clk);
    sbq.push_back(it);
    op_valid    = 1'b1;
    op_code     = 3'(op);
    dst_is_port = dport;
    dst_idx     = IDX_W'(didx);
    dst_off     = OFF_W'(doff);
    src_is_port = sport;
    src_idx     = IDX_W'(sidx);
    src_off     = OFF_W'(soff);
    fld_width   = WID_W'(w);
    port_in     = pin;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  always @(posedge clk) issued_q <= rst ? 1'b0 : op_valid;

  // monitor: compares write-back against the scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (issued_q) begin
        if (sbq.size() == 0) begin
          chk("R8 unexpected write-back", 32'd1, 32'd0);
        end else begin
          exp_t it;
          it = sbq.pop_front();
          chk({it.tag, " wb_valid"}, 32'(wb_valid), 32'(it.wr));
          chk({it.tag, " wb_err"}, 32'(wb_err), 32'(it.err));
          if (it.wr) begin
            chk({it.tag, " wb_to_port"}, 32'(wb_to_port), 32'(it.to_port));
            if (!it.to_port) chk({it.tag, " wb_idx"}, 32'(wb_idx), 32'(it.idx));
            chk({it.tag, " wb_data"}, wb_data, it.data);
          end
          chk("R10 port_out", port_out, mon_port);
          if (it.wr && it.to_port) mon_port = it.data;
        end
      end else begin
        chk("R8 idle strobes", {30'd0, wb_valid, wb_err}, 32'd0);
        chk("R10 port_out", port_out, mon_port);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREGS; r++) mdl[r] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    chk("R11 wb_valid", 32'(wb_valid), 32'd0);
    chk("R11 wb_err", 32'(wb_err), 32'd0);
    chk("R11 port_out", port_out, 32'd0);

    // R1 full-width moves from the input word into every register
    for (int r = 0; r < NREGS; r++)
      issue(0, 1'b0, r, 0, 1'b1, 0, 0, 32, 32'h1357_9BDF ^ (32'h0F0F_3C3C * (r + 1)), "R1");
    idle(2);

    // R1/R5 unaligned moves, width 1 and width 32
    issue(0, 1'b0, 1, 3, 1'b0, 2, 17, 7, '0, "R1");
    issue(0, 1'b0, 3, 31, 1'b0, 4, 0, 1, '0, "R5");
    issue(0, 1'b0, 5, 0, 1'b0, 6, 0, 32, '0, "R5");
    issue(0, 1'b0, 0, 13, 1'b1, 0, 29, 3, 32'hE000_0000, "R1");
    // R2 logic ops with dst as first source
    issue(1, 1'b0, 2, 4, 1'b0, 7, 9, 12, '0, "R2");
    issue(2, 1'b0, 4, 20, 1'b0, 1, 2, 11, '0, "R2");
    issue(3, 1'b0, 6, 1, 1'b0, 0, 1, 30, '0, "R2");
    // R3 inversion
    issue(4, 1'b0, 7, 8, 1'b0, 3, 24, 8, '0, "R3");
    // R4 single-bit field at the top keeps the other 31 bits
    issue(3, 1'b0, 1, 31, 1'b1, 0, 0, 1, 32'h1, "R4");
    idle(2);

    // R6 clipping on the destination side, then on the source side
    issue(0, 1'b0, 2, 28, 1'b1, 0, 0, 8, 32'hFFFF_FFFF, "R6");
    issue(2, 1'b0, 3, 0, 1'b0, 5, 30, 5, '0, "R6");
    issue(1, 1'b0, 4, 0, 1'b1, 0, 0, 40, 32'h0F0F_F0F0, "R6");
    // R7 width 0 and illegal opcodes write nothing
    issue(0, 1'b0, 5, 0, 1'b1, 0, 0, 0, 32'hDEAD_BEEF, "R7");
    issue(6, 1'b0, 5, 0, 1'b1, 0, 0, 16, 32'hDEAD_BEEF, "R7");
    issue(7, 1'b1, 0, 0, 1'b1, 0, 0, 16, 32'hDEAD_BEEF, "R7");
    // observe register 5 through a full move: unchanged by the R7 ops
    issue(0, 1'b0, 6, 0, 1'b0, 5, 0, 32, '0, "R7");
    idle(2);

    // R9 back-to-back chains on one register and on the output word
    issue(0, 1'b0, 2, 0, 1'b1, 0, 0, 32, 32'h0000_0000, "R9");
    issue(2, 1'b0, 2, 5, 1'b1, 0, 0, 4, 32'hFFFF_FFFF, "R9");
    issue(3, 1'b0, 2, 7, 1'b0, 2, 5, 4, '0, "R9");
    issue(0, 1'b0, 3, 10, 1'b0, 2, 3, 10, '0, "R9");
    issue(0, 1'b1, 0, 0, 1'b0, 3, 0, 32, '0, "R10");
    issue(4, 1'b1, 0, 12, 1'b0, 1, 6, 9, '0, "R9");
    issue(1, 1'b1, 0, 2, 1'b1, 0, 27, 5, 32'hA5A5_A5A5, "R10");
    idle(3);

    // R8 commit timing seen on the read-back port
    begin
      logic [DATA_W-1:0] old_v;
      old_v = mdl[4];
      @(negedge clk);
      rd_idx = 3'd4;
      issue(0, 1'b0, 4, 0, 1'b1, 0, 0, 32, ~old_v, "R8");
      @(negedge clk);
      op_valid = 1'b0;
      #1 chk("R8 read before commit", rd_data, old_v);
      @(negedge clk);
      #1 chk("R8 read after commit", rd_data, ~old_v);
    end

    // R4 random stream, compared whole-word
    for (int n = 0; n < 400; n++) begin
      int op, w;
      logic dp, sp;
      op = ($urandom_range(0, 19) == 0) ? 5 : $urandom_range(0, 4);
      w  = ($urandom_range(0, 7) == 0) ? (($urandom_range(0, 1) == 0) ? 1 : 32) : $urandom_range(1, 32);
      dp = ($urandom_range(0, 7) == 0);
      sp = ($urandom_range(0, 5) == 0);
      issue(op, dp, $urandom_range(0, NREGS - 1), $urandom_range(0, 31), sp,
            $urandom_range(0, NREGS - 1), $urandom_range(0, 31), w, $urandom(), "R4");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);

    // R8 final read-back of every register
    for (int r = 0; r < NREGS; r++) begin
      @(negedge clk);
      rd_idx = IDX_W'(r);
      #1 chk("R8 read-back", rd_data, mdl[r]);
    end
    chk("R10 final port_out", port_out, mdl_port);
    chk("R8 scoreboard drained", 32'(sbq.size()), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule